// File: doc/BRIEF.md
# Handshake Ready Throttle for a Five-Channel Memory-Mapped Bus

This block shapes the timing of the ready signals on the five channels of an AXI port. It creates controlled backpressure on both sides of the port. On the subordinate side it drives ready for the write-address, write-data and read-address channels. On the manager side it drives ready for the write-response and read-data channels. It never sees or stores payloads. It only looks at each channel's valid signal and its static configuration, then decides when ready is high.

Every channel has its own delay count and its own mode bit, and each channel runs in one of two modes.

- **Wait mode** (mode bit 0): ready stays low. It rises a set number of cycles after valid appears, and it falls again right after the transfer completes.
- **Resting-high mode** (mode bit 1): ready is normally high. After every completed transfer it is pulled low for the set number of cycles, then it returns high.

The configuration inputs are meant to change only while reset is applied. A verification environment or a stress wrapper uses the block to run many handshake timings through one interface.

Top module: `axi_ready_throttle`

## Requirements
- R1: In wait mode with delay N ≥ 1, ready first goes high N clock edges after the first cycle in which valid is seen high, provided valid is held high throughout.
- R2: In wait mode with delay 0, ready equals valid in the same cycle, with no register in the path.
- R3: In wait mode with delay N ≥ 1, ready is low in the cycle after a handshake. If valid stays high for a next transfer, the N-cycle count starts again from that cycle.
- R4: In wait mode, ready is never high while valid is low.
- R5: In resting-high mode with delay N ≥ 1, ready is high while no handshake has taken place. After a handshake it is low for exactly N cycles, then high again, whatever valid does.
- R6: In resting-high mode with delay 0, ready stays high in every cycle.
- R7: The five channels are independent. Each ready depends only on its own valid, delay count and mode bit.
- R8: Reset is synchronous and active low. While rstN is low, each ready equals its mode bit (high for resting-high, low for wait) regardless of valid. All counters clear, so the first transfer after reset sees the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| awValid | input | 1 | Write-address valid |
| awRestHigh | input | 1 | Write-address mode bit: 1 resting-high, 0 wait |
| awDelay | input | CNT_W | Write-address delay count |
| awReady | output | 1 | Write-address ready |
| wValid | input | 1 | Write-data valid |
| wRestHigh | input | 1 | Write-data mode bit |
| wDelay | input | CNT_W | Write-data delay count |
| wReady | output | 1 | Write-data ready |
| arValid | input | 1 | Read-address valid |
| arRestHigh | input | 1 | Read-address mode bit |
| arDelay | input | CNT_W | Read-address delay count |
| arReady | output | 1 | Read-address ready |
| bValid | input | 1 | Write-response valid |
| bRestHigh | input | 1 | Write-response mode bit |
| bDelay | input | CNT_W | Write-response delay count |
| bReady | output | 1 | Write-response ready |
| rValid | input | 1 | Read-data valid |
| rRestHigh | input | 1 | Read-data mode bit |
| rDelay | input | CNT_W | Read-data delay count |
| rReady | output | 1 | Read-data ready |

## Verification
The bench targets four corner cases, and each one exposes a typical design error:

- **Back-to-back transfers in wait mode.** A design that keeps its count after a handshake would raise ready again at once instead of waiting N more cycles.
- **Delay 0 in wait mode.** A registered design would show a one-cycle lag between valid and ready.
- **Resting-high recovery.** Valid is held high while ready is low. A design that counts only while valid is low, or that stops one cycle early or late, shows a wrong gap length.
- **Reset with valid driven high.** A design that lets ready follow valid during reset, or that keeps a stale count past reset, shows up in the ready level during reset and in the first delay measured afterward.

// File: rtl/axi_bp_pkg.sv
package axi_bp_pkg;
  // Channel lane order used by the top: 0 aw, 1 w, 2 ar, 3 b, 4 r
  localparam int NUM_CH = 5;

  // Strobes sent from the per-lane control to its counter
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
    logic dec;
  } cntCmd_t;
endpackage

// File: rtl/axi_bp_counter.sv
module axi_bp_counter
  import axi_bp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] delay,
  output logic             cntHit,
  output logic             cntZero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)         cnt <= '0;
    else if (cmd.clr)  cnt <= '0;
    else if (cmd.load) cnt <= delay;
    else if (cmd.inc)  cnt <= cnt + 1'b1;
    else if (cmd.dec)  cnt <= cnt - 1'b1;
  end

  assign cntHit  = (cnt == delay);
  assign cntZero = (cnt == '0);

  // The control raises at most one strobe per cycle (supports R1, R5)
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));
  // Counting up never passes the programmed delay (R1)
  a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inc |-> !cntHit);
  // Counting down never wraps below zero (R5)
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> !cntZero);
endmodule

// File: rtl/axi_bp_ctrl.sv
module axi_bp_ctrl
  import axi_bp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic             restHigh,
  input  logic [CNT_W-1:0] delay,
  input  logic             cntHit,
  input  logic             cntZero,
  output logic             ready,
  output cntCmd_t          cmd
);
  logic delayZero;
  assign delayZero = (delay == '0);

  always_comb begin
    cmd   = '0;
    ready = restHigh;
    if (rstN) begin
      if (restHigh) begin
        // Resting-high: low while a recovery count is running
        ready = cntZero;
        if (valid && cntZero) cmd.load = 1'b1;
        else if (!cntZero)    cmd.dec  = 1'b1;
      end else begin
        // Wait mode: ready once valid has been held for delay cycles
        ready = valid && cntHit;
        if (!valid || cntHit) cmd.clr = 1'b1;
        else                  cmd.inc = 1'b1;
      end
    end
  end

  a_r4_ready_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (!restHigh && ready) |-> valid);
  a_r2_zero_follows: assert property (@(posedge clk) disable iff (!rstN)
    (!restHigh && delayZero) |-> (ready == valid));
  a_r3_drop_after_hs: assert property (@(posedge clk) disable iff (!rstN)
    (!restHigh && !delayZero && valid && ready) |=> !ready);
  a_r5_drop_after_hs: assert property (@(posedge clk) disable iff (!rstN)
    (restHigh && !delayZero && valid && ready) |=> !ready);
  a_r6_always_high: assert property (@(posedge clk) disable iff (!rstN)
    (restHigh && delayZero) |-> ready);
  a_r8_reset_level: assert property (@(posedge clk)
    !rstN |-> (ready == restHigh));
endmodule

// File: rtl/axi_ready_throttle.sv
module axi_ready_throttle
  import axi_bp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             awValid,
  input  logic             awRestHigh,
  input  logic [CNT_W-1:0] awDelay,
  output logic             awReady,
  input  logic             wValid,
  input  logic             wRestHigh,
  input  logic [CNT_W-1:0] wDelay,
  output logic             wReady,
  input  logic             arValid,
  input  logic             arRestHigh,
  input  logic [CNT_W-1:0] arDelay,
  output logic             arReady,
  input  logic             bValid,
  input  logic             bRestHigh,
  input  logic [CNT_W-1:0] bDelay,
  output logic             bReady,
  input  logic             rValid,
  input  logic             rRestHigh,
  input  logic [CNT_W-1:0] rDelay,
  output logic             rReady
);
  logic [NUM_CH-1:0] validVec;
  logic [NUM_CH-1:0] restVec;
  logic [NUM_CH-1:0] readyVec;
  logic [CNT_W-1:0]  delayArr [NUM_CH];

  assign validVec = {rValid, bValid, arValid, wValid, awValid};
  assign restVec  = {rRestHigh, bRestHigh, arRestHigh, wRestHigh, awRestHigh};
  assign delayArr[0] = awDelay;
  assign delayArr[1] = wDelay;
  assign delayArr[2] = arDelay;
  assign delayArr[3] = bDelay;
  assign delayArr[4] = rDelay;

  assign awReady = readyVec[0];
  assign wReady  = readyVec[1];
  assign arReady = readyVec[2];
  assign bReady  = readyVec[3];
  assign rReady  = readyVec[4];

  // R7: one independent lane per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    cntCmd_t cmd;
    logic    cntHit;
    logic    cntZero;

    axi_bp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .valid    (validVec[ch]),
      .restHigh (restVec[ch]),
      .delay    (delayArr[ch]),
      .cntHit   (cntHit),
      .cntZero  (cntZero),
      .ready    (readyVec[ch]),
      .cmd      (cmd)
    );

    axi_bp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .cmd     (cmd),
      .delay   (delayArr[ch]),
      .cntHit  (cntHit),
      .cntZero (cntZero)
    );
  end
endmodule

// File: tb/test_axi_ready_throttle.sv
module test_axi_ready_throttle;
  localparam int CNT_W = 8;
  localparam int NCH = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vld [NCH];
  logic rest [NCH];
  logic [CNT_W-1:0] dly [NCH];
  logic awReady, wReady, arReady, bReady, rReady;
  logic [NCH-1:0] rdy;
  int mcnt [NCH];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign rdy = {rReady, bReady, arReady, wReady, awReady};

  always #4 clk = ~clk;

  axi_ready_throttle #(.CNT_W(CNT_W)) i_axi_ready_throttle (
    .clk(clk), .rstN(rstN),
    .awValid(vld[0]), .awRestHigh(rest[0]), .awDelay(dly[0]), .awReady(awReady),
    .wValid(vld[1]),  .wRestHigh(rest[1]),  .wDelay(dly[1]),  .wReady(wReady),
    .arValid(vld[2]), .arRestHigh(rest[2]), .arDelay(dly[2]), .arReady(arReady),
    .bValid(vld[3]),  .bRestHigh(rest[3]),  .bDelay(dly[3]),  .bReady(bReady),
    .rValid(vld[4]),  .rRestHigh(rest[4]),  .rDelay(dly[4]),  .rReady(rReady)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic modelReady(int ch);
    if (rest[ch]) return (mcnt[ch] == 0);
    return vld[ch] && (mcnt[ch] == int'(dly[ch]));
  endfunction

  // Called just after a negedge with inputs set: checks all lanes,
  // advances the model across the next posedge, waits for the next negedge
  task automatic cycle();
    #1;
    for (int ch = 0; ch < NCH; ch++) begin
      logic e;
      e = modelReady(ch);
      check(rest[ch] ? "R5" : "R1", $sformatf("lane %0d model", ch), rdy[ch], e);
      if (rest[ch]) begin
        if (vld[ch] && e) mcnt[ch] = int'(dly[ch]);
        else if (mcnt[ch] > 0) mcnt[ch]--;
      end else begin
        if (!vld[ch] || e) mcnt[ch] = 0;
        else mcnt[ch]++;
      end
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      mcnt[ch] = 0;
      vld[ch] = 1'b0;
    end
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int ch = 0; ch < NCH; ch++) begin
      vld[ch] = 1'b1; rest[ch] = 1'b0; dly[ch] = '0; mcnt[ch] = 0;
    end
    // Directed setup: aw wait N=3, w wait N=0, ar rest N=0, b rest N=2, r rest N=1
    dly[0] = 8'd3; dly[1] = 8'd0;
    rest[2] = 1'b1; dly[2] = 8'd0;
    rest[3] = 1'b1; dly[3] = 8'd2;
    rest[4] = 1'b1; dly[4] = 8'd1;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    // R8: during reset each ready equals its mode bit even with valid high
    check("R8", "aw in reset", awReady, 1'b0);
    check("R8", "w in reset", wReady, 1'b0);
    check("R8", "ar in reset", arReady, 1'b1);
    check("R8", "b in reset", bReady, 1'b1);
    check("R8", "r in reset", rReady, 1'b1);
    @(negedge clk);
    doReset();

    // R1/R3: aw wait mode N=3, valid held high across two transfers
    vld[0] = 1'b1;
    for (int c = 0; c < 8; c++) begin
      #1;
      check((c < 4) ? "R1" : "R3", $sformatf("aw cycle %0d", c), awReady,
            (c == 3 || c == 7) ? 1'b1 : 1'b0);
      // R7: r lane idle in rest mode stays high while aw works
      check("R7", "r idle during aw", rReady, 1'b1);
      cycle();
    end
    vld[0] = 1'b0;

    // R4 / R2: w wait mode N=0
    #1; check("R4", "w ready with valid low", wReady, 1'b0);
    cycle();
    vld[1] = 1'b1;
    #1; check("R2", "w ready same cycle as valid", wReady, 1'b1);
    check("R7", "aw unaffected by w", awReady, 1'b0);
    cycle();
    vld[1] = 1'b0;

    // R5: b rest mode N=2, valid held high
    vld[3] = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      check("R5", $sformatf("b cycle %0d", c), bReady,
            (c == 0 || c == 3) ? 1'b1 : 1'b0);
      cycle();
    end
    vld[3] = 1'b0;

    // R6: ar rest mode N=0 with continuous valid
    vld[2] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1; check("R6", $sformatf("ar cycle %0d", c), arReady, 1'b1);
      cycle();
    end
    vld[2] = 1'b0;

    // Random phases: new configuration under reset, protocol-legal valids
    for (int ph = 0; ph < 40; ph++) begin
      logic hs [NCH];
      for (int ch = 0; ch < NCH; ch++) begin
        rest[ch] = 1'($urandom_range(0, 1));
        dly[ch]  = CNT_W'($urandom_range(0, 4));
        hs[ch]   = 1'b1;
      end
      doReset();
      for (int c = 0; c < 200; c++) begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (!(vld[ch] && !hs[ch])) vld[ch] = ($urandom_range(0, 2) != 0);
        end
        #1;
        for (int ch = 0; ch < NCH; ch++) hs[ch] = vld[ch] && modelReady(ch);
        cycle();
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule